// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside an SDRAM command sequencer and supplies the column address for each data beat of a read or write burst. A 12-bit mode word is loaded through a strobe. The block decodes it into a burst length (1, 2, 4, 8 or a whole 512-column page), a wrap order (sequential or interleaved), a CAS latency (2 or 3) and a flag that forces single-beat writes. When the mode word holds a reserved encoding, the block raises an error flag and refuses to start bursts.

A start strobe, qualified by a read/write flag, loads the first column. Each clock with the advance input high then steps one beat. Fixed-length bursts wrap inside the naturally aligned block that holds the start column. A full-page burst walks all 512 columns and keeps going until the terminate input ends it. A new start may cut into a running burst on any clock, which allows back-to-back commands one clock apart. The outputs are the current column, a valid flag and a last-beat flag. All of them come from registers, so a start seen on one clock edge shows beat 0 right after that edge.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, col_valid and mode_err are 0, cas_lat reads 3, burst_interleave and write_single read 0, and a burst started in this state has a length of one beat.
- R2: A mode_load with a legal word updates the decoded fields on the next clock. Bits [6:4] = 010 gives cas_lat 2 and 011 gives cas_lat 3. Bit 3 drives burst_interleave (1 = interleave). Bit 9 drives write_single. Bits [2:0] = 000/001/010/011/111 give lengths 1/2/4/8/full page.
- R3: A mode_load is reserved if any of these hold: bits [2:0] are 100, 101 or 110; bits [6:4] are not 010 or 011; bits [2:0] are 111 while bit 3 is 1; any of bits [8:7] or [11:10] is nonzero. A reserved load sets mode_err on the next clock and leaves the decoded fields unchanged. While mode_err is 1, start is ignored. A later legal load clears mode_err.
- R4: In sequential order, beat k shows column bits [L-1:0] equal to (start + k) mod 2^L, where 2^L is the burst length. Example: start 5 with length 8 gives 5,6,7,0,1,2,3,4.
- R5: In interleave order, beat k shows column bits [L-1:0] equal to start[L-1:0] XOR k. Example: start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R6: Column bits at and above position L keep the start column's value for the whole fixed-length burst.
- R7: col_last is 1 exactly on beat BL-1 of a fixed-length burst. An advance on that beat drops col_valid on the next clock.
- R8: A full-page burst steps the column by one each beat, wrapping from 511 to 0. It never raises col_last.
- R9: When write_single is 1, a start with start_write = 1 runs a one-beat burst with col_last set on beat 0. A start with start_write = 0 still uses the programmed length.
- R10: A start while mode_err is 0 shows beat 0 (col = start_col) after the next clock edge. This holds even during a running burst, and start takes priority over advance and terminate.
- R11: While col_valid is 1 and start, terminate and advance are all 0, col and col_last hold their values.
- R12: terminate with col_valid = 1 and no start drops col_valid on the next clock, for fixed-length and full-page bursts alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_load | input | 1 | Load strobe for mode_word |
| mode_word | input | 12 | Mode word to decode |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | 9 | First column of the burst |
| start_write | input | 1 | 1 = the burst being started is a write |
| advance | input | 1 | Step to the next beat |
| terminate | input | 1 | End the running burst |
| col | output | 9 | Column address of the current beat |
| col_valid | output | 1 | A burst beat is being presented |
| col_last | output | 1 | Current beat is the final beat |
| mode_err | output | 1 | Last mode load was reserved |
| cas_lat | output | 2 | Decoded CAS latency (2 or 3) |
| burst_interleave | output | 1 | Decoded wrap order, 1 = interleave |
| write_single | output | 1 | Writes are forced to one beat |

## Verification
Lengths 8, 4, 2 and 1 run with start columns whose low bits are not zero, in both sequential and interleaved order. The order checks use the same start column, so only the wrap rule differs between the two sequences, and nonzero upper bits show whether a carry leaks out of the aligned block. A full-page burst starting three columns below the top of the page separates a 9-bit wrap from the block-limited wrap and is ended by terminate. Read and write starts under the single-write mode show that only writes are shortened. Held advance, a mid-burst restart and several reserved words cover the stall, priority and error-blocking paths.

// File: rtl/sbcg_pkg.sv
package sbcg_pkg;

    // Decoded mode fields; lg is log2 of a fixed burst length (0..3)
    typedef struct packed {
        logic [1:0] lg;
        logic       full;
        logic       ilv;
        logic [1:0] cl;
        logic       wsingle;
    } mode_t;

    localparam mode_t MODE_RESET = '{lg: 2'd0, full: 1'b0, ilv: 1'b0,
                                     cl: 2'd3, wsingle: 1'b0};

endpackage

// File: rtl/sbcg_mode_dec.sv
module sbcg_mode_dec
    import sbcg_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input  logic [MODE_W-1:0] word,
    output mode_t             fields,
    output logic              bad
);

    logic len_bad;
    logic cl_bad;
    logic pad_bad;

    always_comb begin
        fields         = MODE_RESET;
        len_bad        = 1'b0;
        cl_bad         = 1'b0;
        fields.ilv     = word[3];
        fields.wsingle = word[9];
        unique case (word[2:0])
            3'b000:  fields.lg = 2'd0;
            3'b001:  fields.lg = 2'd1;
            3'b010:  fields.lg = 2'd2;
            3'b011:  fields.lg = 2'd3;
            3'b111:  fields.full = 1'b1;
            default: len_bad = 1'b1;
        endcase
        unique case (word[6:4])
            3'b010:  fields.cl = 2'd2;
            3'b011:  fields.cl = 2'd3;
            default: cl_bad = 1'b1;
        endcase
        pad_bad = (word[8:7] != 2'b00) || (word[MODE_W-1:10] != '0);
        bad     = len_bad || cl_bad || pad_bad || (fields.full && fields.ilv);
    end

endmodule

// File: rtl/sbcg_col_map.sv
module sbcg_col_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] sum;

    assign sum = base + beat;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = !mask[i] ? base[i]
                      : (ilv ? (base[i] ^ beat[i]) : sum[i]);
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sbcg_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int MODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              start_write,
    input  logic              advance,
    input  logic              terminate,
    output logic [COL_W-1:0]  col,
    output logic              col_valid,
    output logic              col_last,
    output logic              mode_err,
    output logic [1:0]        cas_lat,
    output logic              burst_interleave,
    output logic              write_single
);

    localparam logic [COL_W-1:0] BEAT_ONE = COL_W'(1);

    typedef struct packed {
        mode_t            mode;
        logic             err;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic             ilv;
        logic             full;
        logic             valid;
    } state_t;

    state_t state_d, state_q;
    mode_t  dec_fields;
    logic   dec_bad;
    logic   last_beat;

    function automatic logic [COL_W-1:0] mask_of(mode_t m);
        logic [COL_W-1:0] r;
        for (int i = 0; i < COL_W; i++) begin
            r[i] = m.full || (i < int'(m.lg));
        end
        return r;
    endfunction

    sbcg_mode_dec #(.MODE_W(MODE_W)) u_dec (
        .word   (mode_word),
        .fields (dec_fields),
        .bad    (dec_bad)
    );

    sbcg_col_map #(.COL_W(COL_W)) u_map (
        .base (state_q.base),
        .beat (state_q.beat),
        .mask (state_q.mask),
        .ilv  (state_q.ilv),
        .col  (col)
    );

    assign last_beat = state_q.valid && !state_q.full
                    && (state_q.beat == state_q.mask);

    always_comb begin
        state_d = state_q;
        if (mode_load) begin
            if (dec_bad) begin
                state_d.err = 1'b1;
            end else begin
                state_d.err  = 1'b0;
                state_d.mode = dec_fields;
            end
        end
        if (start && !state_q.err) begin
            state_d.valid = 1'b1;
            state_d.base  = start_col;
            state_d.beat  = '0;
            state_d.ilv   = state_q.mode.ilv;
            if (start_write && state_q.mode.wsingle) begin
                state_d.mask = '0;
                state_d.full = 1'b0;
            end else begin
                state_d.mask = mask_of(state_q.mode);
                state_d.full = state_q.mode.full;
            end
        end else if (state_q.valid && terminate) begin
            state_d.valid = 1'b0;
        end else if (state_q.valid && advance) begin
            if (last_beat) begin
                state_d.valid = 1'b0;
            end else begin
                state_d.beat = state_q.beat + BEAT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{mode: MODE_RESET, err: 1'b0, base: '0, beat: '0,
                         mask: '0, ilv: 1'b0, full: 1'b0, valid: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign col_valid        = state_q.valid;
    assign col_last         = last_beat;
    assign mode_err         = state_q.err;
    assign cas_lat          = state_q.mode.cl;
    assign burst_interleave = state_q.mode.ilv;
    assign write_single     = state_q.mode.wsingle;

endmodule

// File: rtl/sbcg_chk.sv
module sbcg_chk #(
    parameter int COL_W  = 9,
    parameter int MODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_load,
    input logic [MODE_W-1:0] mode_word,
    input logic              start,
    input logic [COL_W-1:0]  start_col,
    input logic              advance,
    input logic              terminate,
    input logic [COL_W-1:0]  col,
    input logic              col_valid,
    input logic              col_last,
    input logic              mode_err
);

    // R10
    start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !mode_err |=> col_valid && (col == $past(start_col)));

    // R12
    terminate_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        terminate && !start && col_valid |=> !col_valid);

    // R11
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !advance && !start && !terminate
        |=> col_valid && $stable(col) && $stable(col_last));

    // R7
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && col_last && advance && !start && !terminate |=> !col_valid);

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R3
    err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err && start && !col_valid |=> !col_valid);

    // R3
    bad_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load && (mode_word[6:4] != 3'b010) && (mode_word[6:4] != 3'b011)
        |=> mode_err);

endmodule

bind sdram_burst_colgen sbcg_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_load (mode_load),
    .mode_word (mode_word),
    .start     (start),
    .start_col (start_col),
    .advance   (advance),
    .terminate (terminate),
    .col       (col),
    .col_valid (col_valid),
    .col_last  (col_last),
    .mode_err  (mode_err)
);

// File: tb/sdram_burst_colgen_tb.sv
`timescale 1ns/1ps
module sdram_burst_colgen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [11:0] mode_word = '0;
    logic        start = 1'b0;
    logic [8:0]  start_col = '0;
    logic        start_write = 1'b0;
    logic        advance = 1'b0;
    logic        terminate = 1'b0;
    logic [8:0]  col;
    logic        col_valid, col_last, mode_err;
    logic [1:0]  cas_lat;
    logic        burst_interleave, write_single;

    always #2.5 clk = ~clk;

    sdram_burst_colgen u_dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .start(start), .start_col(start_col), .start_write(start_write),
        .advance(advance), .terminate(terminate), .col(col),
        .col_valid(col_valid), .col_last(col_last), .mode_err(mode_err),
        .cas_lat(cas_lat), .burst_interleave(burst_interleave),
        .write_single(write_single)
    );

    typedef struct {
        logic [8:0] col;
        logic       last;
        string      req;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    localparam int STOP_END  = 0;
    localparam int STOP_TERM = 1;
    localparam int STOP_INTR = 2;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: every valid beat is compared with the next expected item
    always @(negedge clk) begin
        if (rst_n && col_valid && !done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected beat col", int'(col), 0);
            end else begin
                cur = sb.pop_front();
                check(col == cur.col, cur.req, "column", int'(col), int'(cur.col));
                check(col_last == cur.last, cur.req, "last flag",
                      int'(col_last), int'(cur.last));
            end
        end
    end

    function automatic logic [8:0] model_col(logic [8:0] base, int k, int lg,
                                             bit ilv, bit full);
        int m = full ? 511 : ((1 << lg) - 1);
        int lo = ilv ? ((int'(base) ^ k) & m) : ((int'(base) + k) & m);
        return 9'((int'(base) & ~m & 511) | lo);
    endfunction

    task automatic push_exp(logic [8:0] base, int n, int lg, bit ilv, bit full,
                            int len, string req);
        exp_t e;
        for (int k = 0; k < n; k++) begin
            e.col  = model_col(base, k, lg, ilv, full);
            e.last = !full && (k == len - 1);
            e.req  = req;
            sb.push_back(e);
        end
    endtask

    task automatic load_mode(logic [11:0] w);
        mode_load = 1'b1;
        mode_word = w;
        @(negedge clk);
        mode_load = 1'b0;
        @(negedge clk);
    endtask

    // Starts at a negedge, returns at a negedge
    task automatic run_burst(logic [8:0] c, bit wr, int n, int lg, bit ilv, bit full,
                             int len, int stop, string req);
        push_exp(c, n, lg, ilv, full, len, req);
        start = 1'b1;
        start_col = c;
        start_write = wr;
        @(negedge clk);
        start = 1'b0;
        advance = 1'b1;
        repeat (n - 1) @(negedge clk);
        if (stop == STOP_TERM) begin
            advance = 1'b0;
            terminate = 1'b1;
            @(negedge clk);
            terminate = 1'b0;
            check(!col_valid, req, "valid after terminate", int'(col_valid), 0);
        end else if (stop == STOP_END) begin
            @(negedge clk);
            advance = 1'b0;
            check(!col_valid, req, "valid after last beat", int'(col_valid), 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!col_valid, "R1", "valid", int'(col_valid), 0);
        check(!mode_err, "R1", "mode_err", int'(mode_err), 0);
        check(cas_lat == 2'd3, "R1", "cas_lat", int'(cas_lat), 3);
        check(!burst_interleave, "R1", "interleave", int'(burst_interleave), 0);
        check(!write_single, "R1", "write_single", int'(write_single), 0);
        run_burst(9'h155, 1'b0, 1, 0, 1'b0, 1'b0, 1, STOP_END, "R1");

        // R2 latency 2 decode, length 8 sequential
        load_mode(12'h023);
        check(cas_lat == 2'd2, "R2", "cas_lat", int'(cas_lat), 2);
        check(!mode_err, "R2", "mode_err", int'(mode_err), 0);

        // R4 / R6 sequential length 8 from 0x1A5
        load_mode(12'h033);
        check(cas_lat == 2'd3, "R2", "cas_lat", int'(cas_lat), 3);
        run_burst(9'h1A5, 1'b0, 8, 3, 1'b0, 1'b0, 8, STOP_END, "R4");

        // R5 / R6 interleave length 8 from the same column
        load_mode(12'h03B);
        check(burst_interleave, "R2", "interleave", int'(burst_interleave), 1);
        run_burst(9'h1A5, 1'b0, 8, 3, 1'b1, 1'b0, 8, STOP_END, "R5");

        // R6 length 4 sequential near the top of a block
        load_mode(12'h032);
        run_burst(9'h0FE, 1'b0, 4, 2, 1'b0, 1'b0, 4, STOP_END, "R6");

        // R11 hold with advance low, length 4 sequential
        push_exp(9'h0FE, 1, 2, 1'b0, 1'b0, 4, "R11");
        push_exp(9'h0FE, 4, 2, 1'b0, 1'b0, 4, "R11");
        start = 1'b1;
        start_col = 9'h0FE;
        start_write = 1'b0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        advance = 1'b1;
        repeat (3) @(negedge clk);
        @(negedge clk);
        advance = 1'b0;
        check(!col_valid, "R11", "valid after held burst", int'(col_valid), 0);

        // R5 length 2 interleave
        load_mode(12'h039);
        run_burst(9'h011, 1'b0, 2, 1, 1'b1, 1'b0, 2, STOP_END, "R5");

        // R12 terminate a fixed burst early
        load_mode(12'h033);
        run_burst(9'h040, 1'b0, 3, 3, 1'b0, 1'b0, 8, STOP_TERM, "R12");

        // R10 restart mid-burst, then run the new burst to its end
        run_burst(9'h1A5, 1'b0, 2, 3, 1'b0, 1'b0, 8, STOP_INTR, "R10");
        run_burst(9'h0F3, 1'b0, 8, 3, 1'b0, 1'b0, 8, STOP_END, "R10");

        // R8 full page wraps 511 -> 0, ended by terminate
        load_mode(12'h037);
        run_burst(9'h1FD, 1'b0, 6, 0, 1'b0, 1'b1, 0, STOP_TERM, "R8");

        // R9 single-beat writes, reads keep length 8
        load_mode(12'h233);
        check(write_single, "R9", "write_single", int'(write_single), 1);
        run_burst(9'h1A5, 1'b1, 1, 3, 1'b0, 1'b0, 1, STOP_END, "R9");
        run_burst(9'h1A5, 1'b0, 8, 3, 1'b0, 1'b0, 8, STOP_END, "R9");

        // R3 reserved encodings
        load_mode(12'h034);
        check(mode_err, "R3", "err on length 100", int'(mode_err), 1);
        check(write_single, "R3", "fields kept", int'(write_single), 1);
        start = 1'b1;
        start_col = 9'h010;
        @(negedge clk);
        start = 1'b0;
        check(!col_valid, "R3", "start blocked", int'(col_valid), 0);
        load_mode(12'h033);
        check(!mode_err, "R3", "err cleared", int'(mode_err), 0);
        load_mode(12'h03F);
        check(mode_err, "R3", "err on full interleave", int'(mode_err), 1);
        load_mode(12'h053);
        check(mode_err, "R3", "err on latency 101", int'(mode_err), 1);
        check(cas_lat == 2'd3, "R3", "cas_lat kept", int'(cas_lat), 3);
        load_mode(12'h0B3);
        check(mode_err, "R3", "err on bit 7", int'(mode_err), 1);
        load_mode(12'h023);
        check(!mode_err && cas_lat == 2'd2, "R3", "legal load after error",
              int'(cas_lat), 2);

        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R7", "expected beats left", sb.size(), 0);
        done = 1;
        summary();
    end

endmodule